// File: doc/BRIEF.md
# Sparse Vector Zero-Decompressor

This block rebuilds a dense 512-bit vector from a packed record in word memory. A record starts with a header word. The low 16 bits of the header are a presence mask, one bit per 32-bit lane. The stored lane values follow the header in consecutive words. The block walks the mask from the lowest lane to the highest. Each marked lane takes the next stored word, and each unmarked lane is filled with zero. The record itself describes its layout, so the block has no mode input. The number of words it fetches depends on the data.

A caller presents a word address on `src_ptr` and pulses `start`. The block reads through a request/response port that accepts wait states. When the record has been read, the block pulses `done`. In that same cycle it updates the rebuilt vector and the address just past the record. The caller can pass that address straight back as the next `src_ptr` to read records that sit back to back.

On the request channel, `rd_req_valid` stays high with `rd_req_addr` unchanged until a cycle in which `rd_req_ready` is high. On the response channel, the block holds `rd_rsp_ready` high while it waits, and it takes `rd_rsp_data` in the cycle where `rd_rsp_valid` is also high. The block has at most one read outstanding, and it never raises a request while a response is still owed.

Top module: `sparse_zdecomp`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req_valid` are 0, and `vec_out` and `next_ptr` are all zero.
- R2: The first read of each operation is at `src_ptr`. That word is the header. Header bit i (i = 0..15) marks lane i, which is `vec_out[32*i+31:32*i]`. Header bits 31..16 have no effect.
- R3: After the header, the block reads exactly popcount(header[15:0]) words, at addresses `src_ptr`+1, +2, and so on in order.
- R4: Stored words go to the marked lanes in ascending lane order. The k-th stored word goes to the k-th lowest set bit of the mask.
- R5: Every lane whose header bit is 0 comes out as all-zero bits.
- R6: When `done` is high, `next_ptr` equals `src_ptr` + 1 + popcount(header[15:0]), counted in words.
- R7: A header whose mask is all zeros ends the operation after that single read, and it gives an all-zero vector.
- R8: `done` is a one-cycle pulse with `busy` low. `vec_out` and `next_ptr` change only in the cycle where `done` is high.
- R9: `rd_req_valid` stays high with a stable address until accepted. No request is raised while `rd_rsp_ready` is high, and none is raised while idle.
- R10: A `start` pulse while `busy` is high is ignored. The operation in progress continues with its original pointer.
- R11: Wait states on either read channel change only the timing, never the rebuilt vector or the returned pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding the record at `src_ptr` (taken only when idle) |
| src_ptr | input | 32 | Word address of the record header |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| vec_out | output | 512 | Rebuilt vector, 16 lanes of 32 bits, lane 0 at the low bits |
| next_ptr | output | 32 | Word address just past the last record decoded |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Word address of the read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block is waiting for read data |
| rd_rsp_data | input | 32 | Read data word |

## Verification
A wrong remaining-lane mask shows up in two ways. The count of reads per record is off, and the returned pointer no longer equals the start address plus the reads issued. Both show at the `done` of the same record. A wrong lane pick shows as a misplaced or missing word in `vec_out` at that same pulse. A record built by zeroing random lanes of a dense vector must come back unchanged. If the request handshake breaks under back-pressure, a read is dropped or repeated on the first stalled cycle, and the response count for that record shows it.

// File: rtl/dz_pkg.sv
package dz_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } dz_state_e;
endpackage

// File: rtl/dz_popcnt.sv
module dz_popcnt #(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) count_o = count_o + CW'(bits_i[i]);
  end
endmodule

// File: rtl/dz_lowbit.sv
module dz_lowbit #(
  parameter int W = 16
) (
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] pick_o
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | mask_i[i];
    assign pick_o[i]  = mask_i[i] & ~seen[i];
  end
endmodule

// File: rtl/sparse_zdecomp.sv
module sparse_zdecomp #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  parameter int AW    = 32,
  localparam int VW   = LANES * EW,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_ptr,
  output logic          busy,
  output logic          done,
  output logic [VW-1:0] vec_out,
  output logic [AW-1:0] next_ptr,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [EW-1:0] rd_rsp_data
);
  import dz_pkg::*;

  dz_state_e     state_q;
  logic [AW-1:0] addr_q, base_q, pend_q;
  logic [LANES-1:0] remain_q;
  logic          hdr_q, done_q;
  logic [VW-1:0] work_q, work_d, vec_q;
  logic [AW-1:0] nptr_q;

  logic [LANES-1:0] hdr_mask, pick, remain_after;
  logic [CW-1:0]    hdr_pop;
  logic             rsp_fire, elem_take;
  logic [AW-1:0]    pend_d;

  assign hdr_mask = rd_rsp_data[LANES-1:0];

  dz_popcnt #(.W(LANES)) u_pop (.bits_i(hdr_mask), .count_o(hdr_pop));
  dz_lowbit #(.W(LANES)) u_low (.mask_i(remain_q), .pick_o(pick));

  assign rsp_fire     = (state_q == S_WAIT) && rd_rsp_valid;
  assign elem_take    = rsp_fire && !hdr_q;
  assign remain_after = remain_q & ~pick;
  assign pend_d       = base_q + AW'(1) + AW'(hdr_pop);

  always_comb begin
    work_d = work_q;
    if (elem_take)
      for (int i = 0; i < LANES; i++)
        if (pick[i]) work_d[i*EW +: EW] = rd_rsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      base_q   <= '0;
      pend_q   <= '0;
      remain_q <= '0;
      hdr_q    <= 1'b0;
      done_q   <= 1'b0;
      work_q   <= '0;
      vec_q    <= '0;
      nptr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      work_q <= work_d;
      case (state_q)
        S_IDLE: if (start) begin
          base_q  <= src_ptr;
          addr_q  <= src_ptr;
          work_q  <= '0;
          hdr_q   <= 1'b1;
          state_q <= S_REQ;
        end
        S_REQ: if (rd_req_ready) state_q <= S_WAIT;
        S_WAIT: if (rd_rsp_valid) begin
          if (hdr_q) begin
            hdr_q    <= 1'b0;
            remain_q <= hdr_mask;
            pend_q   <= pend_d;
            if (hdr_mask == '0) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              vec_q   <= '0;
              nptr_q  <= pend_d;
            end else begin
              addr_q  <= addr_q + AW'(1);
              state_q <= S_REQ;
            end
          end else begin
            remain_q <= remain_after;
            if (remain_after == '0) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              vec_q   <= work_d;
              nptr_q  <= pend_q;
            end else begin
              addr_q  <= addr_q + AW'(1);
              state_q <= S_REQ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != S_IDLE);
  assign done         = done_q;
  assign vec_out      = vec_q;
  assign next_ptr     = nptr_q;
  assign rd_req_valid = (state_q == S_REQ);
  assign rd_req_addr  = addr_q;
  assign rd_rsp_ready = (state_q == S_WAIT);
endmodule

// File: rtl/sparse_zdecomp_chk.sv
module sparse_zdecomp_chk #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  parameter int AW    = 32,
  localparam int VW   = LANES * EW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] src_ptr,
  input logic          busy,
  input logic          done,
  input logic [VW-1:0] vec_out,
  input logic [AW-1:0] next_ptr,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          rd_rsp_valid,
  input logic          rd_rsp_ready
);
  logic [AW-1:0] base_c, cnt_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_c <= '0;
      cnt_c  <= '0;
    end else if (start && !busy) begin
      base_c <= src_ptr;
      cnt_c  <= '0;
    end else if (rd_req_valid && rd_req_ready) begin
      cnt_c <= cnt_c + AW'(1);
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !rd_rsp_ready);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !rd_rsp_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> done || ($stable(vec_out) && $stable(next_ptr)));
  p_addr_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |-> rd_req_addr == base_c + cnt_c);
  p_ptr_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> next_ptr == base_c + cnt_c);
endmodule

bind sparse_zdecomp sparse_zdecomp_chk #(.LANES(LANES), .EW(EW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_ptr(src_ptr), .busy(busy),
  .done(done), .vec_out(vec_out), .next_ptr(next_ptr),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
  .rd_rsp_ready(rd_rsp_ready)
);

// File: tb/sim_sparse_zdecomp.sv
module sim_sparse_zdecomp;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] src_ptr = '0;
  logic busy, done, rd_req_valid, rd_rsp_ready;
  logic [511:0] vec_out;
  logic [31:0] next_ptr, rd_req_addr;
  logic rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;

  always #5 clk = ~clk;

  sparse_zdecomp u0 (.*);

  logic [31:0] mem [0:255];
  int n_cmp = 0, n_bad = 0, ops_done = 0, nreads = 0;
  logic [31:0] first_addr;
  bit got_first = 0, stall_on = 0;
  bit pend = 0, req_fire = 0, rsp_fire = 0;
  logic [31:0] pend_addr;
  int dly = 0;

  logic [511:0] q_vec [$];
  logic [31:0]  q_ptr [$], q_src [$];
  int           q_rd [$];
  string        q_tag [$];
  logic [511:0] last_vec = '0;
  logic [31:0]  last_ptr = '0;
  bit hold_bad = 0;

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // memory responder with optional wait states
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_req_ready = 0; rd_rsp_valid = 0; pend = 0; req_fire = 0; rsp_fire = 0;
    end else begin
      if (rsp_fire) begin rd_rsp_valid = 0; pend = 0; rsp_fire = 0; end
      if (req_fire) begin pend = 1; dly = stall_on ? int'($urandom % 4) : 0; req_fire = 0; end
      rd_req_ready = 0;
      if (!pend && rd_req_valid && (!stall_on || ($urandom % 3) == 0)) begin
        rd_req_ready = 1; req_fire = 1; pend_addr = rd_req_addr; nreads++;
        if (!got_first) begin got_first = 1; first_addr = rd_req_addr; end
      end
      if (pend && !rd_rsp_valid) begin
        if (dly == 0) begin rd_rsp_valid = 1; rd_rsp_data = mem[pend_addr[7:0]]; end
        else dly--;
      end
      if (rd_rsp_valid && rd_rsp_ready) rsp_fire = 1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        string t;
        t = q_tag.pop_front();
        chk({t, " R4 R5 vector"}, vec_out, q_vec.pop_front());
        chk({t, " R6 next_ptr"}, 512'(next_ptr), 512'(q_ptr.pop_front()));
        chk({t, " R3 read count"}, 512'(nreads), 512'(q_rd.pop_front()));
        chk({t, " R2 first address"}, 512'(first_addr), 512'(q_src.pop_front()));
        chk({t, " R8 outputs held before done"}, 512'(hold_bad), 512'(0));
        chk({t, " R8 busy low at done"}, 512'(busy), 512'(0));
        hold_bad = 0; last_vec = vec_out; last_ptr = next_ptr;
        ops_done++;
      end else if (vec_out !== last_vec || next_ptr !== last_ptr) hold_bad = 1;
    end
  end

  // driver: record from dense vector (lane kept when nonzero)
  task automatic run_op(input string tag, input logic [7:0] ptr, input logic [511:0] dense,
                        input logic [15:0] hi, input bit dbl);
    logic [15:0] mask = '0;
    int k = 0;
    int target;
    for (int i = 0; i < 16; i++)
      if (dense[i*32 +: 32] != 0) begin
        mask[i] = 1'b1;
        mem[8'(ptr + 8'd1 + 8'(k))] = dense[i*32 +: 32];
        k++;
      end
    mem[ptr] = {hi, mask};
    q_vec.push_back(dense); q_ptr.push_back(32'(ptr) + 32'd1 + 32'(k));
    q_rd.push_back(1 + k); q_src.push_back(32'(ptr)); q_tag.push_back(tag);
    target = ops_done + 1;
    @(negedge clk);
    nreads = 0; got_first = 0; start = 1; src_ptr = 32'(ptr);
    @(negedge clk);
    start = 0;
    if (dbl) begin
      @(negedge clk);
      chk({tag, " R10 busy during op"}, 512'(busy), 512'(1));
      start = 1; src_ptr = 32'(ptr) + 32'd77;
      @(negedge clk);
      start = 0;
    end
    wait (ops_done == target);
  endtask

  function automatic logic [511:0] sparse_vec(input logic [15:0] keep, input logic [7:0] salt);
    logic [511:0] v = '0;
    for (int i = 0; i < 16; i++)
      if (keep[i]) v[i*32 +: 32] = {salt, 8'(i), 16'hC300 + 16'(i)};
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: run did not complete actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    repeat (3) @(negedge clk);
    chk("R1 busy", 512'(busy), 0);
    chk("R1 done", 512'(done), 0);
    chk("R1 req_valid", 512'(rd_req_valid), 0);
    chk("R1 vec_out", vec_out, 0);
    chk("R1 next_ptr", 512'(next_ptr), 0);
    rst_n = 1;
    @(negedge clk);

    run_op("R7 empty header", 8'd10, '0, 16'h0, 0);
    run_op("R3 full header", 8'd20, sparse_vec(16'hFFFF, 8'h11), 16'h0, 0);
    run_op("R4 lane 15 only", 8'd40, sparse_vec(16'h8000, 8'h22), 16'h0, 0);
    run_op("R4 lane 0 only", 8'd45, sparse_vec(16'h0001, 8'h23), 16'h0, 0);
    run_op("R2 upper header bits ignored", 8'd50, sparse_vec(16'h5A5A, 8'h33), 16'hFFFF, 0);
    run_op("R7 empty header with upper bits", 8'd70, '0, 16'hABCD, 0);
    run_op("R10 start while busy", 8'd80, sparse_vec(16'h0F0F, 8'h44), 16'h0, 1);
    // back-to-back records, chained through next_ptr (R6)
    run_op("R6 chain a", 8'd100, sparse_vec(16'h0003, 8'h55), 16'h0, 0);
    run_op("R6 chain b", 8'(last_ptr), sparse_vec(16'hC000, 8'h56), 16'h0, 0);
    run_op("R6 chain c", 8'(last_ptr), sparse_vec(16'h0810, 8'h57), 16'h0, 0);
    stall_on = 1;
    for (int n = 0; n < 8; n++) begin
      logic [511:0] d;
      for (int i = 0; i < 16; i++) begin
        d[i*32 +: 32] = $urandom;
        if (d[i*32 +: 32] == 0) d[i*32 +: 32] = 32'h1;
        if (($urandom % 2) == 0) d[i*32 +: 32] = '0;
      end
      run_op("R11 round trip with wait states", 8'(130 + n * 14), d, 16'(n), 0);
    end
    run_op("R11 full header with wait states", 8'd20, sparse_vec(16'hFFFF, 8'h11), 16'h0, 0);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule